// File: doc/BRIEF.md
# Timer Input Capture Unit

This block keeps one free-running time base and lets eight channels timestamp events on their input pins against it. The counter is never cleared by channel activity, so software measures an interval by subtracting two captured values. The counter advances from one of four tick sources: every bus clock, every rising edge of an external accumulator clock, or that accumulator clock divided by one of two powers of two. A run bit gates all counting. When the counter wraps to zero it raises an overflow flag. That flag is cleared by a write of 1, or by any access to the counter register when fast clear is on.

Each channel passes its pin through a synchronizer and then watches it for a programmed edge type. On a qualifying edge it copies the counter into a holding register and sets its flag. The flag drives an interrupt line when the channel's enable bit is set. A per-channel direction bit hands the pin over to output compare, which is implemented elsewhere, and while that bit is set the channel never captures.

The register port is a flat 4-bit address space with write and read strobes and combinational read data. The map is: 0 control, 1 direction, 2 edge select, 3 interrupt enable, 4 channel flags, 5 overflow flag, 6 counter, and 8+n holding register of channel n.

Top module: `timer_capture_unit`

## Requirements
- R1: After reset the counter, all holding registers, all channel flags, the overflow flag, the control, direction, edge and enable registers, and both interrupt outputs are zero.
- R2: With control bit 0 (run) set, the counter at address 6 advances by exactly one per selected tick and wraps from all ones to zero. With run clear it holds its value. Captures and writes to address 6 never change it.
- R3: Control bits [3:2] select the tick. 00 gives every bus clock. 01 gives every rising edge of acc_clk. 10 gives every 2^LO_SHIFT rising edges of acc_clk. 11 gives every 2^HI_SHIFT rising edges.
- R4: The overflow flag (address 6 wrap, read at address 5 bit 0) sets in the cycle the counter wraps to zero. A write to address 5 with bit 0 set clears it, and a write with bit 0 clear leaves it alone. A wrap in the same cycle as a clear leaves it set.
- R5: With control bit 1 (fast clear) set, a read or write strobe at address 6 clears the overflow flag. With that bit clear, such a strobe leaves the flag unchanged.
- R6: Edge select bits [2n+1:2n] at address 2 set channel n's trigger. 00 captures nothing, 01 captures rising edges, 10 captures falling edges, and 11 captures both.
- R7: On a qualifying edge, channel n's holding register (address 8+n) receives the counter value present two clock edges after the edge that first samples the new pin level, and flag bit n at address 4 sets.
- R8: While direction bit n at address 1 is 1, channel n captures nothing: its flag and holding register stay unchanged on any pin activity.
- R9: Writing address 4 clears each flag whose data bit is 1 and leaves the flags written with 0 unchanged. A capture in the same cycle as its clear leaves the flag set.
- R10: irq_ch[n] is high exactly when flag n and enable bit n at address 3 are both 1. irq_ovf is high exactly when the overflow flag and control bit 4 are both 1.
- R11: The control (5 bits), direction, edge select and interrupt enable registers read back the values last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_pins | input | NCH | Channel input pins, asynchronous |
| acc_clk | input | 1 | Accumulator clock, sampled and edge-detected |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (counts as a counter access for fast clear) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| irq_ch | output | NCH | Per-channel interrupt requests |
| irq_ovf | output | 1 | Counter overflow interrupt request |

## Verification
The bench builds the unit with an 8-bit counter and divider shifts of 2 and 4, keeping all eight channels. The short counter brings a wrap within a few hundred cycles, so the overflow flag, its write-1 clear and fast clear can be exercised several times each. The small dividers let each tick source be measured over an exact whole number of its own periods. Every channel is swept through all four edge codes with both a rising and a falling transition, and each capture is predicted from a counter value read in the cycle the pin changed.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_DIR    = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_EDGE   = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_IEN    = 4'h3;
  localparam logic [ADDR_W-1:0] ADDR_CHFLAG = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_OVF    = 4'h5;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 4'h6;

  typedef enum logic [1:0] {
    CKSEL_BUS    = 2'b00,
    CKSEL_ACC    = 2'b01,
    CKSEL_ACC_LO = 2'b10,
    CKSEL_ACC_HI = 2'b11
  } cksel_e;

  localparam int unsigned CTRL_W = 5;

  typedef struct packed {
    logic   ovf_ie;
    cksel_e sel;
    logic   fast_clr;
    logic   run;
  } ctrl_t;

endpackage

// File: rtl/tcu_prescaler.sv
module tcu_prescaler import tcu_pkg::*; #(
  parameter int unsigned LO_SHIFT    = 8,
  parameter int unsigned HI_SHIFT    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   acc_clk,
  input  cksel_e sel,
  output logic   tick
);

  logic [SYNC_STAGES-1:0] acc_sync_q;
  logic                   acc_last_q;
  logic                   acc_rise;
  logic [HI_SHIFT-1:0]    div_q;
  logic [HI_SHIFT-1:0]    div_d;
  logic                   lo_wrap;
  logic                   hi_wrap;

  assign acc_rise = acc_sync_q[SYNC_STAGES-1] & ~acc_last_q;
  assign lo_wrap  = &div_q[LO_SHIFT-1:0];
  assign hi_wrap  = &div_q;

  always_comb begin
    div_d = div_q + HI_SHIFT'(1);
  end

  always_comb begin
    unique case (sel)
      CKSEL_BUS:    tick = 1'b1;
      CKSEL_ACC:    tick = acc_rise;
      CKSEL_ACC_LO: tick = acc_rise & lo_wrap;
      CKSEL_ACC_HI: tick = acc_rise & hi_wrap;
      default:      tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_sync_q <= '0;
      acc_last_q <= 1'b0;
    end else begin
      acc_sync_q <= {acc_sync_q[SYNC_STAGES-2:0], acc_clk};
      acc_last_q <= acc_sync_q[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (acc_rise) begin
      div_q <= div_d;
    end
  end

  AST_ACC_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != CKSEL_BUS && tick) |=> (!tick || sel == CKSEL_BUS)); // R3

endmodule

// File: rtl/tcu_timebase.sv
module tcu_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_q;
  logic             ovf_d;
  logic             wrap;

  always_comb begin
    wrap  = adv && (cnt_q == '1);
    cnt_d = cnt_q + CNT_W'(1);
    ovf_d = wrap | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;

  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_q == '1) |=> (ovf_q && cnt_q == '0)); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q)); // R2

  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !(adv && cnt_q == '1)) |=> !ovf_q); // R4

endmodule

// File: rtl/tcu_capture_chan.sv
module tcu_capture_chan #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             is_oc,
  input  logic [1:0]       edge_sel,
  input  logic             clr_req,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] hold,
  output logic             flag
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   pin_now;
  logic                   rise;
  logic                   fall;
  logic                   cap_hit;
  logic [CNT_W-1:0]       hold_q;
  logic                   flag_q;
  logic                   flag_d;

  always_comb begin
    pin_now = sync_q[SYNC_STAGES-1];
    rise    = pin_now & ~last_q;
    fall    = ~pin_now & last_q;
    cap_hit = ~is_oc & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
    flag_d  = cap_hit | (flag_q & ~clr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      last_q <= pin_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (cap_hit) begin
      hold_q <= cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign hold = hold_q;
  assign flag = flag_q;

  AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (flag_q && hold_q == $past(cnt))); // R7

  AST_OC_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    is_oc |=> $stable(hold_q)); // R8

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !cap_hit) |=> !flag_q); // R9

  AST_EDGE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'b00 && !flag_q) |=> !flag_q); // R6

endmodule

// File: rtl/timer_capture_unit.sv
module timer_capture_unit import tcu_pkg::*; #(
  parameter int unsigned NCH         = 8,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned LO_SHIFT    = 8,
  parameter int unsigned HI_SHIFT    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cap_pins,
  input  logic              acc_clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    irq_ch,
  output logic              irq_ovf
);

  localparam int unsigned EDGE_W = 2 * NCH;

  logic [1:0]       rst_pipe_q;
  logic             core_rst_n;

  ctrl_t            ctrl_q, ctrl_d;
  logic [NCH-1:0]   dir_q, dir_d;
  logic [NCH-1:0]   ien_q, ien_d;
  logic [EDGE_W-1:0] edge_q, edge_d;

  logic             wr_ctrl, wr_dir, wr_edge, wr_ien, wr_flag, wr_ovf;
  logic             cnt_access;
  logic             fc_clr;
  logic             ovf_clr;
  logic [NCH-1:0]   clr_vec;

  logic             tick;
  logic             adv;
  logic [CNT_W-1:0] cnt;
  logic             ovf;

  logic [CNT_W-1:0] hold_w [NCH];
  logic [NCH-1:0]   flag_w;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe_q[1];

  // register write decode
  always_comb begin
    wr_ctrl    = wr_en && (addr == ADDR_CTRL);
    wr_dir     = wr_en && (addr == ADDR_DIR);
    wr_edge    = wr_en && (addr == ADDR_EDGE);
    wr_ien     = wr_en && (addr == ADDR_IEN);
    wr_flag    = wr_en && (addr == ADDR_CHFLAG);
    wr_ovf     = wr_en && (addr == ADDR_OVF);
    cnt_access = (wr_en || rd_en) && (addr == ADDR_COUNT);
    fc_clr     = cnt_access && ctrl_q.fast_clr;
    ovf_clr    = (wr_ovf && wdata[0]) || fc_clr;
    clr_vec    = wr_flag ? wdata[NCH-1:0] : '0;
  end

  always_comb begin
    ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    dir_d  = wdata[NCH-1:0];
    ien_d  = wdata[NCH-1:0];
    edge_d = wdata[EDGE_W-1:0];
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      dir_q <= '0;
    end else if (wr_dir) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ien_q <= '0;
    end else if (wr_ien) begin
      ien_q <= ien_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      edge_q <= '0;
    end else if (wr_edge) begin
      edge_q <= edge_d;
    end
  end

  tcu_prescaler #(
    .LO_SHIFT   (LO_SHIFT),
    .HI_SHIFT   (HI_SHIFT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_presc (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .acc_clk(acc_clk),
    .sel    (ctrl_q.sel),
    .tick   (tick)
  );

  assign adv = ctrl_q.run & tick;

  tcu_timebase #(
    .CNT_W(CNT_W)
  ) u_tbase (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .adv    (adv),
    .ovf_clr(ovf_clr),
    .cnt    (cnt),
    .ovf    (ovf)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    tcu_capture_chan #(
      .CNT_W      (CNT_W),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_chan (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .pin_in  (cap_pins[g]),
      .is_oc   (dir_q[g]),
      .edge_sel(edge_q[2*g +: 2]),
      .clr_req (clr_vec[g]),
      .cnt     (cnt),
      .hold    (hold_w[g]),
      .flag    (flag_w[g])
    );
  end

  assign irq_ch  = flag_w & ien_q;
  assign irq_ovf = ovf & ctrl_q.ovf_ie;

  // read mux, combinational
  always_comb begin
    rdata = '0;
    if (addr[ADDR_W-1]) begin
      for (int i = 0; i < NCH; i++) begin
        if (addr[ADDR_W-2:0] == (ADDR_W-1)'(i)) rdata[CNT_W-1:0] = hold_w[i];
      end
    end else begin
      unique case (addr)
        ADDR_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
        ADDR_DIR:    rdata[NCH-1:0]    = dir_q;
        ADDR_EDGE:   rdata[EDGE_W-1:0] = edge_q;
        ADDR_IEN:    rdata[NCH-1:0]    = ien_q;
        ADDR_CHFLAG: rdata[NCH-1:0]    = flag_w;
        ADDR_OVF:    rdata[0]          = ovf;
        ADDR_COUNT:  rdata[CNT_W-1:0]  = cnt;
        default:     rdata             = '0;
      endcase
    end
  end

  AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (!core_rst_n)
    fc_clr |=> (!ovf || cnt == '0)); // R5

  AST_COUNT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cnt_access && !adv) |=> $stable(cnt)); // R2

endmodule

// File: tb/timer_capture_unit_test.sv
module timer_capture_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 8;
  localparam int CNT_W = 8;
  localparam int LO    = 2;
  localparam int HI    = 4;
  localparam int CMOD  = 1 << CNT_W;

  localparam logic [3:0] A_CTRL = 4'h0, A_DIR = 4'h1, A_EDGE = 4'h2, A_IEN = 4'h3,
                         A_FLAG = 4'h4, A_OVF = 4'h5, A_CNT = 4'h6, A_HOLD = 4'h8;

  logic        clk;
  logic        rst_n;
  logic [7:0]  pins;
  logic        acc_clk;
  logic [3:0]  addr;
  logic        wr_en;
  logic        rd_en;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [7:0]  irq_ch;
  logic        irq_ovf;

  int nvec;
  int nfail;
  int exp_hold [NCH];

  timer_capture_unit #(
    .NCH(NCH), .CNT_W(CNT_W), .LO_SHIFT(LO), .HI_SHIFT(HI), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cap_pins(pins), .acc_clk(acc_clk),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .irq_ch(irq_ch), .irq_ovf(irq_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // accumulator clock: rising edge every 4 bus clocks
  initial acc_clk = 1'b0;
  always begin
    repeat (2) @(negedge clk);
    acc_clk = ~acc_clk;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [3:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    addr  = a;
    wdata = 16'(d);
    wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic strobe(input logic [3:0] a, input bit is_wr, input int d);
    @(negedge clk);
    addr  = a;
    wdata = 16'(d);
    wr_en = is_wr;
    rd_en = !is_wr;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    rd_en = 1'b0;
  endtask

  // drive pin n to lvl, predict capture from counter (sel 00, run on)
  task automatic cap(input int n, input bit lvl, input bit hit, input string tag);
    int c0, c1, v;
    @(negedge clk);
    pins[n] = lvl;
    peek(A_CNT, c0);
    repeat (4) @(negedge clk);
    peek(A_CNT, c1);
    chk("R2 counter unaffected by capture", c1, (c0 + 4) % CMOD);
    if (hit) exp_hold[n] = (c0 + 2) % CMOD;
    peek(A_FLAG, v);
    chk({tag, " flag"}, v, hit ? (1 << n) : 0);
    peek(A_HOLD + 4'(n), v);
    chk({tag, " hold"}, v, exp_hold[n]);
  endtask

  task automatic rate(input int ctrl, input int m, input int exp, input string tag);
    int c0, c1;
    wr(A_CTRL, ctrl);
    repeat (8) @(negedge clk);
    peek(A_CNT, c0);
    repeat (m) @(negedge clk);
    peek(A_CNT, c1);
    chk(tag, (c1 - c0 + CMOD) % CMOD, exp);
  endtask

  task automatic wait_wrap();
    int c;
    @(negedge clk);
    peek(A_CNT, c);
    repeat (CMOD - c) @(negedge clk);
  endtask

  initial begin
    int v, c0;
    pins = '0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    nvec = 0; nfail = 0;
    for (int i = 0; i < NCH; i++) exp_hold[i] = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(A_CNT, v);  chk("R1 counter", v, 0);
    peek(A_FLAG, v); chk("R1 flags", v, 0);
    peek(A_OVF, v);  chk("R1 overflow", v, 0);
    peek(A_CTRL, v); chk("R1 control", v, 0);
    peek(A_EDGE, v); chk("R1 edge select", v, 0);
    for (int i = 0; i < NCH; i++) begin
      peek(A_HOLD + 4'(i), v); chk("R1 hold", v, 0);
    end
    chk("R1 irq", {23'd0, irq_ovf, irq_ch}, 0);
    repeat (10) @(negedge clk);
    peek(A_CNT, v); chk("R2 counter held while stopped", v, 0);

    // R2 / R3 tick sources
    rate(32'h01, 40,   40, "R2 R3 bus clock tick");
    rate(32'h05, 64,   16, "R3 acc clock tick");
    rate(32'h09, 64,    4, "R3 acc divided low");
    rate(32'h0D, 1024, 16, "R3 acc divided high");
    rate(32'h0C, 64,    0, "R2 stopped");
    rate(32'h01, 100, 100, "R2 bus clock tick again");

    // R4 overflow flag
    wr(A_OVF, 1);
    @(negedge clk);
    peek(A_CNT, v);
    while (v >= CMOD - 8 || v == 0) begin
      @(negedge clk);
      peek(A_CNT, v);
    end
    repeat (CMOD - 1 - v) @(negedge clk);
    peek(A_CNT, v); chk("R4 counter at max", v, CMOD - 1);
    peek(A_OVF, v); chk("R4 no overflow before wrap", v, 0);
    @(negedge clk);
    peek(A_CNT, v); chk("R2 wrap to zero", v, 0);
    peek(A_OVF, v); chk("R4 overflow on wrap", v, 1);
    chk("R10 irq_ovf disabled", irq_ovf, 0);
    wr(A_CTRL, 32'h11);
    @(negedge clk); chk("R10 irq_ovf enabled", irq_ovf, 1);
    wr(A_OVF, 0);
    @(negedge clk); peek(A_OVF, v); chk("R4 write 0 keeps flag", v, 1);
    wr(A_OVF, 1);
    @(negedge clk); peek(A_OVF, v); chk("R4 write 1 clears", v, 0);
    chk("R10 irq_ovf drops", irq_ovf, 0);

    // R5 fast clear
    wr(A_CTRL, 32'h01);
    wait_wrap();
    peek(A_OVF, v); chk("R4 set again", v, 1);
    strobe(A_CNT, 1'b0, 0);
    @(negedge clk); peek(A_OVF, v); chk("R5 read ignored without fast clear", v, 1);
    wr(A_CTRL, 32'h03);
    strobe(A_CNT, 1'b0, 0);
    @(negedge clk); peek(A_OVF, v); chk("R5 read clears", v, 0);
    wait_wrap();
    peek(A_OVF, v); chk("R4 set third time", v, 1);
    strobe(A_CNT, 1'b1, 0);
    @(negedge clk); peek(A_OVF, v); chk("R5 write clears", v, 0);
    wr(A_CTRL, 32'h01);

    // R2: write to counter ignored
    @(negedge clk);
    peek(A_CNT, c0);
    strobe(A_CNT, 1'b1, (c0 + 77) % CMOD);
    @(negedge clk);
    peek(A_CNT, v); chk("R2 counter write ignored", v, (c0 + 2) % CMOD);

    // R6 R7 sweep: every channel, every edge code, both transitions
    wr(A_DIR, 0);
    wr(A_IEN, 0);
    for (int n = 0; n < NCH; n++) begin
      for (int e = 0; e < 4; e++) begin
        wr(A_EDGE, 0);
        pins = '0;
        repeat (4) @(negedge clk);
        wr(A_FLAG, 32'hFF);
        wr(A_EDGE, e << (2 * n));
        cap(n, 1'b1, (e & 1) != 0, "R6 R7 rising");
        wr(A_FLAG, 32'hFF);
        cap(n, 1'b0, (e & 2) != 0, "R6 R7 falling");
        wr(A_FLAG, 32'hFF);
      end
    end

    // R9 write-1 clear and masking
    wr(A_EDGE, 1 << 6);
    cap(3, 1'b1, 1'b1, "R7 ch3 rising");
    wr(A_FLAG, 32'hF7);
    @(negedge clk); peek(A_FLAG, v); chk("R9 zero bit keeps flag", v, 32'h08);
    wr(A_FLAG, 32'h08);
    @(negedge clk); peek(A_FLAG, v); chk("R9 one bit clears", v, 0);

    // R9 capture wins over same-cycle clear
    wr(A_EDGE, 3 << 6);
    cap(3, 1'b0, 1'b1, "R6 ch3 both edges falling");
    @(negedge clk);
    pins[3] = 1'b1;
    peek(A_CNT, c0);
    @(negedge clk);
    @(negedge clk);
    addr = A_FLAG; wdata = 16'h0008; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    @(negedge clk);
    peek(A_FLAG, v); chk("R9 capture beats clear", v, 32'h08);
    exp_hold[3] = (c0 + 2) % CMOD;
    peek(A_HOLD + 4'd3, v); chk("R7 hold on clear cycle", v, exp_hold[3]);
    wr(A_FLAG, 32'hFF);

    // R8 output-compare direction blocks capture
    wr(A_DIR, 32'h20);
    wr(A_EDGE, 3 << 10);
    cap(5, 1'b1, 1'b0, "R8 dir set rising");
    cap(5, 1'b0, 1'b0, "R8 dir set falling");
    wr(A_DIR, 0);
    cap(5, 1'b1, 1'b1, "R8 dir cleared rising");

    // R10 channel interrupts
    @(negedge clk); chk("R10 irq_ch masked", irq_ch, 0);
    wr(A_IEN, 32'h20);
    @(negedge clk); chk("R10 irq_ch raised", irq_ch, 32'h20);
    wr(A_FLAG, 32'h20);
    @(negedge clk); chk("R10 irq_ch cleared", irq_ch, 0);

    // R11 readback
    wr(A_DIR, 32'hA5);
    wr(A_EDGE, 32'h1234);
    wr(A_IEN, 32'h5A);
    wr(A_CTRL, 32'h1B);
    @(negedge clk);
    peek(A_DIR, v);  chk("R11 direction", v, 32'hA5);
    peek(A_EDGE, v); chk("R11 edge select", v, 32'h1234);
    peek(A_IEN, v);  chk("R11 enables", v, 32'h5A);
    peek(A_CTRL, v); chk("R11 control", v, 32'h1B);

    summary();
    $finish;
  end

endmodule